// File: doc/BRIEF.md
# Multi-Channel DMA Service Engine

The engine keeps one descriptor for each channel. A descriptor holds a source address, a destination address, a size code, a byte count, two end-of-transfer address adjustments, and a small control/status word. A channel is served when its number arrives on the request input. Requests wait in a first-in first-out queue. The engine takes them one at a time and checks each descriptor before moving any data. It copies the data in beats whose width comes from the size code. Each beat is a read from the source followed by a write to the destination. At the end it updates the descriptor's addresses and status bits and raises that channel's done or error interrupt.

A global cancel input empties the queue at the next point between two channel services. The channel being served at that moment finishes normally. When the cancel carries the log flag, the engine records the channel it served last in an error-status word.

Software sets up descriptors through a register port that can write and read every field. It clears interrupt bits by pulsing the matching acknowledge line.

Top module: `dma_svc_engine`

## Requirements
- R1: After reset every descriptor field, every interrupt bit and the error-status word read zero, and no memory access is issued.
- R2: Size code (attribute field bits 2:0) 0 selects 1-byte beats, codes 1 and 4 select 2-byte beats, and code 2 selects 4-byte beats. `mem_size` carries the beat width as a power of two (0, 1 or 2), and every beat address is aligned to it.
- R3: A descriptor fails its check if any of these holds: the size code is not one of 0, 1, 2 or 4; the byte count is zero; the byte count is not a multiple of the beat width; either address is misaligned to the beat width. A failing channel gets its `err_irq` bit set and its status word set to DONE only (value 4). It makes no memory access, raises no done interrupt, and keeps its addresses unchanged.
- R4: When a valid channel starts, its status word becomes ACTIVE only (value 2). This clears any START (bit 0) or DONE (bit 2) and sets ACTIVE (bit 1).
- R5: A transfer is byte count divided by beat width beats. Each beat is a read at the source, with the write of that data to the destination in the next cycle. Both addresses advance by the beat width after each beat.
- R6: On completion the stored source address becomes its original value plus the source adjustment, and the stored destination address becomes its original value plus the destination adjustment. The status word becomes DONE only (value 4), and the channel's `done_irq` bit is set.
- R7: Queued channels are served in the order their requests were accepted.
- R8: A request for a channel that is already waiting in the queue is dropped.
- R9: A cancel empties the queue after the current service, so no flushed channel is served. If the cancel had `cancel_log` high, the error-status word (register select 7) reads bit 31 valid, bit 8 cancel, and the last-served channel in its low bits. Without the flag, the error-status word is unchanged.
- R10: A 1 on `done_ack[i]` or `err_ack[i]` clears only that channel's bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Service request strobe |
| req_ch | input | CW | Requested channel |
| cancel_req | input | 1 | Flush the request queue |
| cancel_log | input | 1 | Record the cancel in the error-status word |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | CW | Register channel |
| cfg_sel | input | 3 | Field: 0 src, 1 dst, 2 size code, 3 count, 4 src adjust, 5 dst adjust, 6 status, 7 error status (write clears) |
| cfg_wdata | input | AW | Register write data |
| cfg_rdata | output | AW | Register read data for `cfg_ch`/`cfg_sel` |
| mem_re | output | 1 | Memory read, data returned next cycle |
| mem_we | output | 1 | Memory write |
| mem_addr | output | AW | Memory byte address |
| mem_size | output | 2 | Beat width as log2 of bytes |
| mem_wdata | output | 32 | Write data, low lanes |
| mem_rdata | input | 32 | Read data, low lanes |
| done_ack | input | NCH | Clear done interrupt bits |
| err_ack | input | NCH | Clear error interrupt bits |
| done_irq | output | NCH | Per-channel done interrupts |
| err_irq | output | NCH | Per-channel error bits and interrupts |

## Verification
The copy path is tried with every legal size code, with odd and even byte counts, with one-beat and multi-beat transfers, and with positive and negative adjustments. Comparing beat counts and copied bytes separates width decoding errors from address stepping errors. Descriptors that fail each check on its own (bad code, zero count, ragged count, misaligned source, misaligned destination) show that no single check is missing. Queue tests make the engine busy with a long channel while others queue, repeat, or get cancelled. This separates ordering, duplicate suppression and flushing, with and without the log flag.

// File: rtl/dma_svc_engine.sv
module dma_svc_engine #(
  parameter int NCH = 4,
  parameter int AW  = 32,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [CW-1:0] req_ch,
  input  logic          cancel_req,
  input  logic          cancel_log,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_ch,
  input  logic [2:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] cfg_rdata,
  output logic          mem_re,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic [NCH-1:0] done_ack,
  input  logic [NCH-1:0] err_ack,
  output logic [NCH-1:0] done_irq,
  output logic [NCH-1:0] err_irq
);
  localparam logic [2:0] ST_ACTIVE = 3'b010;
  localparam logic [2:0] ST_DONE   = 3'b100;

  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_RD, S_WR, S_FIN} state_t;

  logic [AW-1:0] saddr [NCH];
  logic [AW-1:0] daddr [NCH];
  logic [AW-1:0] nbytes[NCH];
  logic [AW-1:0] sadj  [NCH];
  logic [AW-1:0] dadj  [NCH];
  logic [2:0]    scode [NCH];
  logic [2:0]    csr   [NCH];

  logic [CW-1:0] q [NCH];
  logic [CW-1:0] q_rd, q_wr;
  logic [CW:0]   q_cnt;
  logic [NCH-1:0] queued;

  state_t        state;
  logic [CW-1:0] cur;
  logic [AW-1:0] wsrc, wdst, wcnt;
  logic [1:0]    lg;
  logic          cancel_pend, cancel_log_q;
  logic [CW-1:0] esr_ch;
  logic          esr_ecx, esr_vld;

  function automatic logic [2:0] size_dec(input logic [2:0] c);
    case (c)
      3'd0:       return 3'b100;
      3'd1, 3'd4: return 3'b101;
      3'd2:       return 3'b110;
      default:    return 3'b000;
    endcase
  endfunction

  function automatic logic [CW-1:0] nxt(input logic [CW-1:0] p);
    return (p == CW'(NCH - 1)) ? '0 : p + 1'b1;
  endfunction

  wire           flush = (state == S_IDLE) && cancel_pend;
  wire           pop   = (state == S_IDLE) && !cancel_pend && (q_cnt != '0);
  wire           enq   = req_valid && (int'(req_ch) < NCH) && !queued[req_ch] && !flush;

  wire [2:0]     cdec  = size_dec(scode[cur]);
  wire [AW-1:0]  cmask = {{(AW-2){1'b0}}, ~(2'b11 << cdec[1:0])};
  wire           cur_ok = cdec[2] && (nbytes[cur] != '0) &&
                          ((nbytes[cur] & cmask) == '0) &&
                          ((saddr[cur] & cmask) == '0) &&
                          ((daddr[cur] & cmask) == '0);
  wire [AW-1:0]  beat  = AW'(1) << lg;

  assign mem_re    = (state == S_RD);
  assign mem_we    = (state == S_WR);
  assign mem_addr  = (state == S_WR) ? wdst : wsrc;
  assign mem_size  = lg;
  assign mem_wdata = mem_rdata;

  always_comb begin
    case (cfg_sel)
      3'd0:    cfg_rdata = saddr[cfg_ch];
      3'd1:    cfg_rdata = daddr[cfg_ch];
      3'd2:    cfg_rdata = AW'(scode[cfg_ch]);
      3'd3:    cfg_rdata = nbytes[cfg_ch];
      3'd4:    cfg_rdata = sadj[cfg_ch];
      3'd5:    cfg_rdata = dadj[cfg_ch];
      3'd6:    cfg_rdata = AW'(csr[cfg_ch]);
      default: begin
        cfg_rdata = '0;
        cfg_rdata[AW-1] = esr_vld;
        cfg_rdata[8] = esr_ecx;
        cfg_rdata[CW-1:0] = esr_ch;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_rd <= '0;
      q_wr <= '0;
      q_cnt <= '0;
      queued <= '0;
      for (int i = 0; i < NCH; i++) q[i] <= '0;
    end else if (flush) begin
      q_rd <= '0;
      q_wr <= '0;
      q_cnt <= '0;
      queued <= '0;
    end else begin
      if (enq) begin
        q[q_wr] <= req_ch;
        q_wr <= nxt(q_wr);
        queued[req_ch] <= 1'b1;
      end
      if (pop) begin
        q_rd <= nxt(q_rd);
        queued[q[q_rd]] <= 1'b0;
      end
      q_cnt <= q_cnt + (CW+1)'(enq) - (CW+1)'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cancel_pend  <= 1'b0;
      cancel_log_q <= 1'b0;
    end else if (cancel_req) begin
      cancel_pend  <= 1'b1;
      cancel_log_q <= cancel_log;
    end else if (flush) begin
      cancel_pend  <= 1'b0;
      cancel_log_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        saddr[i] <= '0;
        daddr[i] <= '0;
        nbytes[i] <= '0;
        sadj[i] <= '0;
        dadj[i] <= '0;
        scode[i] <= '0;
        csr[i] <= '0;
      end
      state <= S_IDLE;
      cur <= '0;
      wsrc <= '0;
      wdst <= '0;
      wcnt <= '0;
      lg <= '0;
      esr_ch <= '0;
      esr_ecx <= 1'b0;
      esr_vld <= 1'b0;
      done_irq <= '0;
      err_irq <= '0;
    end else begin
      done_irq <= done_irq & ~done_ack;
      err_irq  <= err_irq & ~err_ack;
      if (cfg_we) begin
        case (cfg_sel)
          3'd0: saddr[cfg_ch] <= cfg_wdata;
          3'd1: daddr[cfg_ch] <= cfg_wdata;
          3'd2: scode[cfg_ch] <= cfg_wdata[2:0];
          3'd3: nbytes[cfg_ch] <= cfg_wdata;
          3'd4: sadj[cfg_ch] <= cfg_wdata;
          3'd5: dadj[cfg_ch] <= cfg_wdata;
          3'd6: csr[cfg_ch] <= cfg_wdata[2:0];
          default: begin
            esr_ch <= '0;
            esr_ecx <= 1'b0;
            esr_vld <= 1'b0;
          end
        endcase
      end
      if (flush && cancel_log_q) begin
        esr_ch <= cur;
        esr_ecx <= 1'b1;
        esr_vld <= 1'b1;
      end
      case (state)
        S_IDLE: if (pop) begin
          cur <= q[q_rd];
          state <= S_CHECK;
        end
        S_CHECK: if (!cur_ok) begin
          err_irq[cur] <= 1'b1;
          csr[cur] <= ST_DONE;
          state <= S_IDLE;
        end else begin
          csr[cur] <= ST_ACTIVE;
          wsrc <= saddr[cur];
          wdst <= daddr[cur];
          wcnt <= nbytes[cur];
          lg <= cdec[1:0];
          state <= S_RD;
        end
        S_RD: state <= S_WR;
        S_WR: begin
          wsrc <= wsrc + beat;
          wdst <= wdst + beat;
          wcnt <= wcnt - beat;
          state <= (wcnt == beat) ? S_FIN : S_RD;
        end
        S_FIN: begin
          saddr[cur] <= saddr[cur] + sadj[cur];
          daddr[cur] <= daddr[cur] + dadj[cur];
          csr[cur] <= ST_DONE;
          done_irq[cur] <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_svc_checker.sv
module dma_svc_checker #(
  parameter int NCH = 4,
  parameter int AW  = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mem_re,
  input logic           mem_we,
  input logic [AW-1:0]  mem_addr,
  input logic [1:0]     mem_size,
  input logic [NCH-1:0] done_irq,
  input logic [NCH-1:0] err_irq
);
  a_r5_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> mem_we);

  a_r5_one_access: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));

  a_r2_legal_size: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re || mem_we) |-> (mem_size != 2'd3));

  a_r2_aligned_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re || mem_we) |-> ((mem_addr[1:0] & ~(2'b11 << mem_size)) == 2'b00));

  a_r3_err_without_done: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_irq & ~$past(err_irq)) & (done_irq & ~$past(done_irq))) == '0);

  a_r6_one_completion: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(done_irq & ~$past(done_irq)) <= 1);

  a_r3_no_access_on_error: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_irq & ~$past(err_irq)) != '0) |-> !$past(mem_we));
endmodule

bind dma_svc_engine dma_svc_checker #(.NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_re(mem_re), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_size(mem_size),
  .done_irq(done_irq), .err_irq(err_irq)
);

// File: tb/tb_dma_svc_engine.sv
module tb_dma_svc_engine;
  localparam int NCH = 4;
  localparam int AW = 32;
  localparam int CW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, cancel_req = 1'b0, cancel_log = 1'b0, cfg_we = 1'b0;
  logic [CW-1:0] req_ch = '0, cfg_ch = '0;
  logic [2:0] cfg_sel = '0;
  logic [AW-1:0] cfg_wdata = '0, cfg_rdata, mem_addr;
  logic mem_re, mem_we;
  logic [1:0] mem_size;
  logic [31:0] mem_wdata, rdata_q;
  logic [NCH-1:0] done_ack = '0, err_ack = '0, done_irq, err_irq;

  always #10 clk = ~clk;

  dma_svc_engine #(.NCH(NCH), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ch(req_ch),
    .cancel_req(cancel_req), .cancel_log(cancel_log), .cfg_we(cfg_we),
    .cfg_ch(cfg_ch), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_rdata(rdata_q), .done_ack(done_ack), .err_ack(err_ack),
    .done_irq(done_irq), .err_irq(err_irq));

  logic [7:0] mem [256];
  logic [7:0] orig [256];
  int reads = 0;
  int cyc = 0;
  int done_t [NCH];
  logic [NCH-1:0] prev_done = '0;
  int total = 0, bad = 0;
  logic finished = 1'b0;

  always @(posedge clk) begin
    logic [7:0] a;
    cyc <= cyc + 1;
    a = mem_addr[7:0];
    if (mem_re) begin
      reads = reads + 1;
      rdata_q <= {mem[8'(a+3)], mem[8'(a+2)], mem[8'(a+1)], mem[a]};
    end
    if (mem_we) begin
      mem[a] = mem_wdata[7:0];
      if (mem_size >= 2'd1) mem[8'(a+1)] = mem_wdata[15:8];
      if (mem_size == 2'd2) begin
        mem[8'(a+2)] = mem_wdata[23:16];
        mem[8'(a+3)] = mem_wdata[31:24];
      end
    end
  end

  always @(negedge clk) begin
    for (int i = 0; i < NCH; i++)
      if (done_irq[i] && !prev_done[i]) done_t[i] = cyc;
    prev_done = done_irq;
  end

  typedef struct packed {
    logic [1:0] ch; logic [2:0] ss;
    logic [31:0] s, d, n, sl, dl;
    logic ok;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 3'd0, 32'h10, 32'h80, 32'd5,  32'hFFFF_FFFB, 32'd3,         1'b1},
    '{2'd1, 3'd1, 32'h20, 32'h90, 32'd6,  32'h100,       32'd0,         1'b1},
    '{2'd2, 3'd2, 32'h30, 32'hA0, 32'd12, 32'd4,         32'hFFFF_FFF4, 1'b1},
    '{2'd3, 3'd4, 32'h42, 32'hB2, 32'd4,  32'd0,         32'd8,         1'b1},
    '{2'd0, 3'd3, 32'h10, 32'h80, 32'd4,  32'd0,         32'd0,         1'b0},
    '{2'd1, 3'd2, 32'h20, 32'h90, 32'd0,  32'd0,         32'd0,         1'b0},
    '{2'd2, 3'd2, 32'h30, 32'hA0, 32'd6,  32'd0,         32'd0,         1'b0},
    '{2'd3, 3'd1, 32'h21, 32'h90, 32'd4,  32'd0,         32'd0,         1'b0},
    '{2'd0, 3'd2, 32'h30, 32'hA2, 32'd4,  32'd0,         32'd0,         1'b0},
    '{2'd1, 3'd5, 32'h20, 32'h90, 32'd4,  32'd0,         32'd0,         1'b0},
    '{2'd2, 3'd0, 32'h7F, 32'hC0, 32'd1,  32'd1,         32'd1,         1'b1}
  };

  task automatic chk(input logic cond, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int sel, input logic [31:0] v);
    cfg_we = 1'b1; cfg_ch = CW'(ch); cfg_sel = 3'(sel); cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input int ch, input int sel, output logic [31:0] v);
    cfg_ch = CW'(ch); cfg_sel = 3'(sel);
    #1 v = cfg_rdata;
  endtask

  task automatic prog(input int ch, input int ss, input logic [31:0] s, input logic [31:0] d,
                      input logic [31:0] n, input logic [31:0] sl, input logic [31:0] dl);
    wr(ch, 0, s); wr(ch, 1, d); wr(ch, 2, 32'(ss));
    wr(ch, 3, n); wr(ch, 4, sl); wr(ch, 5, dl);
  endtask

  task automatic req(input int ch);
    req_valid = 1'b1; req_ch = CW'(ch);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic ack_all();
    done_ack = '1; err_ack = '1;
    @(negedge clk);
    done_ack = '0; err_ack = '0;
  endtask

  task automatic wait_ch(input int ch);
    for (int k = 0; k < 400; k++) begin
      if (done_irq[ch] || err_irq[ch]) break;
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 7 + seed + 1);
      orig[i] = mem[i];
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    fill(0);
    idle(3);
    // R1 reset state
    chk(done_irq == '0 && err_irq == '0, "R1 irqs", {done_irq, err_irq}, 0);
    chk(!mem_re && !mem_we, "R1 mem idle", {mem_re, mem_we}, 0);
    rd(0, 7, v); chk(v == 0, "R1 error status", v, 0);
    rd(2, 0, v); chk(v == 0, "R1 source address", v, 0);
    rd(3, 6, v); chk(v == 0, "R1 status word", v, 0);
    rst_n = 1'b1;
    idle(2);

    // R2 R3 R5 R6 vector walk
    for (int i = 0; i < NV; i++) begin
      vec_t t;
      int lg, exp_reads;
      logic good;
      t = VEC[i];
      lg = (t.ss == 3'd0) ? 0 : (t.ss == 3'd2) ? 2 : 1;
      ack_all();
      fill(i);
      prog(t.ch, t.ss, t.s, t.d, t.n, t.sl, t.dl);
      reads = 0;
      req(t.ch);
      wait_ch(t.ch);
      idle(2);
      if (t.ok) begin
        exp_reads = t.n >> lg;
        chk(done_irq[t.ch] && !err_irq[t.ch], $sformatf("R6 done vec%0d", i), {done_irq, err_irq}, 1);
        chk(reads == exp_reads, $sformatf("R2 beat count vec%0d", i), reads, exp_reads);
        good = 1'b1;
        for (int k = 0; k < int'(t.n); k++)
          if (mem[8'(t.d + k)] !== orig[8'(t.s + k)]) good = 1'b0;
        chk(good, $sformatf("R5 copied data vec%0d", i), good, 1);
        chk(mem[8'(t.d + t.n)] == orig[8'(t.d + t.n)], $sformatf("R5 no overrun vec%0d", i),
            mem[8'(t.d + t.n)], orig[8'(t.d + t.n)]);
        rd(t.ch, 0, v); chk(v == t.s + t.sl, $sformatf("R6 source adjust vec%0d", i), v, t.s + t.sl);
        rd(t.ch, 1, v); chk(v == t.d + t.dl, $sformatf("R6 dest adjust vec%0d", i), v, t.d + t.dl);
      end else begin
        chk(err_irq[t.ch] && !done_irq[t.ch], $sformatf("R3 error flag vec%0d", i), {done_irq, err_irq}, 1);
        chk(reads == 0, $sformatf("R3 no access vec%0d", i), reads, 0);
        rd(t.ch, 0, v); chk(v == t.s, $sformatf("R3 source kept vec%0d", i), v, t.s);
      end
      rd(t.ch, 6, v); chk(v == 4, $sformatf("R3 R6 status done vec%0d", i), v, 4);
    end

    // R4 status while active
    ack_all();
    prog(2, 0, 32'h10, 32'h80, 32'd16, 0, 0);
    wr(2, 6, 32'h5);
    req(2);
    idle(3);
    rd(2, 6, v); chk(v == 2, "R4 active status", v, 2);
    wait_ch(2);

    // R7 order
    ack_all();
    prog(3, 0, 32'h10, 32'h80, 32'd16, 0, 0);
    prog(1, 0, 32'h40, 32'hC0, 32'd2, 0, 0);
    prog(0, 0, 32'h50, 32'hD0, 32'd2, 0, 0);
    req(3); req(1); req(0);
    wait_ch(0);
    idle(2);
    chk(done_irq[3] && done_irq[1] && done_irq[0], "R7 all served", done_irq, 4'hB);
    chk(done_t[3] < done_t[1] && done_t[1] < done_t[0], "R7 order", done_t[1], done_t[0]);

    // R8 duplicate
    ack_all();
    prog(1, 0, 32'h40, 32'hC0, 32'd4, 0, 0);
    reads = 0;
    req(3); req(1); req(1);
    wait_ch(1);
    idle(40);
    chk(reads == 20, "R8 duplicate dropped", reads, 20);

    // R9 cancel with log
    ack_all();
    wr(0, 7, 0);
    req(3); req(0); req(1);
    cancel_req = 1'b1; cancel_log = 1'b1;
    @(negedge clk);
    cancel_req = 1'b0; cancel_log = 1'b0;
    wait_ch(3);
    idle(20);
    chk(done_irq[0] == 1'b0 && done_irq[1] == 1'b0, "R9 flushed", done_irq, 4'h8);
    rd(0, 7, v); chk(v == 32'h8000_0103, "R9 error status logged", v, 32'h8000_0103);
    req(0);
    wait_ch(0);
    idle(2);
    chk(done_irq[0], "R9 queue usable after flush", done_irq, 4'h9);

    // R9 cancel without log
    ack_all();
    wr(0, 7, 0);
    req(3); req(1);
    cancel_req = 1'b1;
    @(negedge clk);
    cancel_req = 1'b0;
    wait_ch(3);
    idle(20);
    chk(done_irq[1] == 1'b0, "R9 flushed no log", done_irq, 4'h8);
    rd(0, 7, v); chk(v == 0, "R9 status untouched", v, 0);

    // R10 acknowledge
    req(1);
    wait_ch(1);
    idle(2);
    done_ack = 4'b1000;
    @(negedge clk);
    done_ack = '0;
    chk(done_irq == 4'b0010, "R10 done ack one bit", done_irq, 4'b0010);
    wr(2, 2, 7); req(2); wait_ch(2);
    wr(1, 2, 7); req(1); wait_ch(1);
    idle(2);
    err_ack = 4'b0100;
    @(negedge clk);
    err_ack = '0;
    chk(err_irq == 4'b0010, "R10 error ack one bit", err_irq, 4'b0010);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule